// File: doc/BRIEF.md
# Four-Channel Event Record Packer

This block watches four channel inputs and turns each change on them into a 32-bit event record. The record combines a running count of elapsed seconds with the number of the channel that moved. The block writes that record, one byte per accepted transfer, into a byte-wide store through a simple write port. A local seconds counter advances on a one-cycle tick input, so whatever provides the time base only has to pulse that input.

Change detection compares the current input levels with a stored reference. The comparison is an exclusive-OR, and the reference is refreshed on every sample, so each change is reported once. If several inputs move in the same cycle, one record is made for the lowest-numbered channel. A record that arrives while the previous one is still being written waits in a single holding slot. Anything beyond that slot is discarded. After a fixed number of records the store counts as full, the full output goes high and every later event is discarded.

Top module: `evt_record_packer`

## Requirements
- R1: After reset, mem_we and full are low, the seconds count is zero, and the levels present on ch_in at reset release become the reference without producing a record.
- R2: A record is produced in the cycle where ch_in differs from the reference (bitwise exclusive-OR is nonzero). The reference then takes the sampled value, so a level that stays put produces no further record.
- R3: When several inputs differ in the same sample, only the lowest index among them is recorded (ch_in[0] is channel 0, ch_in[3] is channel 3).
- R4: Record bits 31:30 hold the channel number as an unsigned 2-bit value. Bits 29:0 hold the seconds count in the sampling cycle, before any tick in that same cycle takes effect.
- R5: The seconds count starts at zero and rises by one at every clock edge where sec_tick is high, including consecutive cycles.
- R6: Record number n (counting from 0 in order of acceptance) goes to addresses 4n, 4n+1, 4n+2 and 4n+3, holding record bits 31:24, 23:16, 15:8 and 7:0 in that order.
- R7: While mem_we is high and mem_rdy is low, mem_we, mem_addr and mem_data hold their values. A byte is taken only at an edge where both are high.
- R8: An event that arrives while a record is being written is held in one pending slot and written next. An event that arrives while both the writer and the pending slot are occupied is discarded and never written.
- R9: Once 2000 records have been accepted, full goes high and stays high until reset. Later events are discarded, and no address at or above 8000 is ever written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ch_in | input | 4 | Channel input levels, synchronous to clk |
| sec_tick | input | 1 | Advances the seconds count by one per high cycle |
| mem_rdy | input | 1 | Store accepts the presented byte this cycle |
| mem_addr | output | 13 | Byte address in the store |
| mem_data | output | 8 | Byte to be written |
| mem_we | output | 1 | Write request, held until accepted |
| full | output | 1 | Record capacity reached |

## Verification
Two functions can fall in the same clock cycle. One is the writer finishing the last byte of a record and pulling the pending record into the byte serialiser. The other is a new event claiming the slot that has just been freed, while the ready input is held low or toggles pseudo-randomly. The bench provokes both orders. It stalls the store, fires three events back to back, and then releases the store. It also fires events while the ready input is toggling. A scoreboard compares every accepted byte and its address against records that the bench builds from its own model of the channel reference and of the tick count, and it reports any write it did not predict.

// File: rtl/evt_pkg.sv
package evt_pkg;
    localparam int SEC_W  = 30;
    localparam int CHN_W  = 2;
    localparam int REC_W  = SEC_W + CHN_W;
    localparam int BYTE_W = 8;
    localparam int BPR    = REC_W / BYTE_W;   // bytes per record
    localparam int BSEL_W = $clog2(BPR);

    typedef struct packed {
        logic [CHN_W-1:0] chan;
        logic [SEC_W-1:0] secs;
    } evt_rec_t;
endpackage

// File: rtl/evt_chg_detect.sv
module evt_chg_detect #(
    parameter int NUM_CH = 4,
    localparam int IDX_W = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] ch_in,
    output logic              ev_valid,
    output logic [IDX_W-1:0]  ev_ch
);
    typedef struct packed {
        logic              primed;
        logic [NUM_CH-1:0] base;
    } det_state_t;

    det_state_t st_d, st_q;
    logic [NUM_CH-1:0] diff;

    always_comb begin
        st_d        = st_q;
        diff        = ch_in ^ st_q.base;
        ev_valid    = st_q.primed && (diff != '0);
        ev_ch       = '0;
        // scan downward so the lowest changed index is left last
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (diff[i]) ev_ch = IDX_W'(i);
        end
        st_d.primed = 1'b1;
        st_d.base   = ch_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2: an unchanged input level cannot fire twice in a row
    assert_no_repeat_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid |=> (!ev_valid || ch_in != $past(ch_in)));
    // R3: the reported channel really differs from the reference
    assert_chan_changed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid |-> (ch_in[ev_ch] != st_q.base[ev_ch]));
endmodule

// File: rtl/evt_sec_counter.sv
module evt_sec_counter
    import evt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sec_tick,
    output logic [SEC_W-1:0] secs
);
    typedef struct packed {
        logic [SEC_W-1:0] cnt;
    } sec_state_t;

    sec_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sec_tick) st_d.cnt = st_q.cnt + 1'b1;
        secs = st_q.cnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R5: count moves only on a tick
    assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !sec_tick |=> $stable(secs));
endmodule

// File: rtl/evt_rec_writer.sv
module evt_rec_writer
    import evt_pkg::*;
#(
    parameter int MAX_RECS = 2000,
    parameter int ADDR_W   = 13,
    localparam int IDX_W   = $clog2(MAX_RECS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_valid,
    input  evt_rec_t          ev_rec,
    input  logic              mem_rdy,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BYTE_W-1:0] mem_data,
    output logic              mem_we,
    output logic              full
);
    typedef struct packed {
        logic              busy;
        logic [BSEL_W-1:0] bsel;
        evt_rec_t          cur;
        logic              pend_v;
        evt_rec_t          pend;
        logic [IDX_W-1:0]  wr_idx;
        logic [IDX_W-1:0]  acc_cnt;
    } wr_state_t;

    wr_state_t st_d, st_q;
    logic byte_done, rec_done, take_ev;

    always_comb begin
        st_d      = st_q;
        full      = (st_q.acc_cnt == IDX_W'(MAX_RECS));
        byte_done = st_q.busy && mem_rdy;
        rec_done  = byte_done && (st_q.bsel == BSEL_W'(BPR - 1));
        take_ev   = 1'b0;

        if (byte_done) st_d.bsel = st_q.bsel + 1'b1;
        if (rec_done) begin
            st_d.busy   = 1'b0;
            st_d.wr_idx = st_q.wr_idx + 1'b1;
        end

        // waiting record moves up as soon as the serialiser frees
        if (!st_d.busy && st_q.pend_v) begin
            st_d.busy   = 1'b1;
            st_d.bsel   = '0;
            st_d.cur    = st_q.pend;
            st_d.pend_v = 1'b0;
        end

        if (ev_valid && !full) begin
            if (!st_d.busy) begin
                st_d.busy = 1'b1;
                st_d.bsel = '0;
                st_d.cur  = ev_rec;
                take_ev   = 1'b1;
            end else if (!st_d.pend_v) begin
                st_d.pend_v = 1'b1;
                st_d.pend   = ev_rec;
                take_ev     = 1'b1;
            end
        end
        if (take_ev) st_d.acc_cnt = st_q.acc_cnt + 1'b1;

        mem_we   = st_q.busy;
        mem_addr = ADDR_W'({st_q.wr_idx, st_q.bsel});
        mem_data = BYTE_W'(st_q.cur >> {~st_q.bsel, 3'b000});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R7: a stalled byte keeps its request, address and data
    assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !mem_rdy) |=> (mem_we && $stable(mem_addr) && $stable(mem_data)));
    // R8: a waiting record implies the serialiser is occupied
    assert_pend_behind_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pend_v |-> st_q.busy);
    // R9: full never drops before reset
    assert_full_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        full |=> full);
    // R9: writes stay below the capacity boundary
    assert_addr_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (int'(mem_addr) < MAX_RECS * BPR));
endmodule

// File: rtl/evt_record_packer.sv
module evt_record_packer
    import evt_pkg::*;
#(
    parameter int NUM_CH    = 4,
    parameter int MAX_RECS  = 2000,
    parameter int MEM_DEPTH = 8192,
    localparam int ADDR_W   = $clog2(MEM_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] ch_in,
    input  logic              sec_tick,
    input  logic              mem_rdy,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_data,
    output logic              mem_we,
    output logic              full
);
    logic             ev_valid;
    logic [CHN_W-1:0] ev_ch;
    logic [SEC_W-1:0] secs;
    evt_rec_t         ev_rec;

    evt_chg_detect #(.NUM_CH(NUM_CH)) u_det (
        .clk      (clk),
        .rst_n    (rst_n),
        .ch_in    (ch_in),
        .ev_valid (ev_valid),
        .ev_ch    (ev_ch)
    );

    evt_sec_counter u_sec (
        .clk      (clk),
        .rst_n    (rst_n),
        .sec_tick (sec_tick),
        .secs     (secs)
    );

    always_comb begin
        ev_rec.chan = ev_ch;
        ev_rec.secs = secs;
    end

    evt_rec_writer #(.MAX_RECS(MAX_RECS), .ADDR_W(ADDR_W)) u_wr (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev_valid (ev_valid),
        .ev_rec   (ev_rec),
        .mem_rdy  (mem_rdy),
        .mem_addr (mem_addr),
        .mem_data (mem_data),
        .mem_we   (mem_we),
        .full     (full)
    );

    // R1: nothing is requested or flagged in the cycle after reset release
    assert_quiet_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!mem_we && !full));
endmodule

// File: tb/evt_record_packer_tb_top.sv
module evt_record_packer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  ch_in = 4'b1010;
    logic        sec_tick = 1'b0;
    logic        mem_rdy = 1'b1;
    logic [12:0] mem_addr;
    logic [7:0]  mem_data;
    logic        mem_we;
    logic        full;

    int checks = 0;
    int fails = 0;
    int bsec = 0;
    int nrec = 0;
    int rdy_mode = 0;
    logic [3:0]  cur = 4'b1010;
    logic [15:0] lfsr = 16'hACE1;
    logic [20:0] exp_q[$];

    always #2 clk = ~clk;

    evt_record_packer dut_i (
        .clk(clk), .rst_n(rst_n), .ch_in(ch_in), .sec_tick(sec_tick),
        .mem_rdy(mem_rdy), .mem_addr(mem_addr), .mem_data(mem_data),
        .mem_we(mem_we), .full(full)
    );

    always @(negedge clk) begin
        case (rdy_mode)
            0: mem_rdy <= 1'b1;
            1: begin
                lfsr    <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                mem_rdy <= lfsr[3];
            end
            default: mem_rdy <= 1'b0;
        endcase
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // monitor: pop and compare each accepted byte
    always @(negedge clk) begin
        #1;
        if (rst_n && mem_we && mem_rdy) begin
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R8 unexpected write actual=%0h expected=none",
                         {mem_addr, mem_data});
            end else begin
                logic [20:0] e;
                e = exp_q.pop_front();
                if ({mem_addr, mem_data} != e) begin
                    fails++;
                    $display("FAIL R4 R6 byte actual=%0h/%0h expected=%0h/%0h",
                             mem_addr, mem_data, e[20:8], e[7:0]);
                end
            end
        end
    end

    task automatic push_rec(input logic [1:0] ch, input int secs);
        logic [31:0] rec;
        rec = {ch, 30'(secs)};
        for (int k = 0; k < 4; k++)
            exp_q.push_back({13'(nrec * 4 + k), rec[31 - 8*k -: 8]});
        nrec++;
    endtask

    task automatic fire(input logic [3:0] v, input bit accept);
        logic [3:0] d;
        logic [1:0] ch;
        d  = v ^ cur;
        ch = 2'd0;
        for (int i = 3; i >= 0; i--) if (d[i]) ch = 2'(i);
        @(negedge clk);
        ch_in = v;
        cur   = v;
        if (accept) push_rec(ch, bsec);
    endtask

    task automatic tick_n(input int n);
        @(negedge clk);
        sec_tick = 1'b1;
        repeat (n) @(negedge clk);
        sec_tick = 1'b0;
        bsec += n;
    endtask

    task automatic drain(input string tag);
        int w = 0;
        @(negedge clk);
        while ((exp_q.size() != 0 || mem_we) && w < 400) begin
            @(negedge clk);
            w++;
        end
        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0 && !mem_we, tag, exp_q.size(), 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R6 writer progress actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [12:0] a0;
        logic [7:0]  d0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        // R1: quiet after reset, input levels at release become reference
        chk(!mem_we, "R1 mem_we after reset", mem_we, 0);
        chk(!full, "R1 full after reset", full, 0);
        chk(exp_q.size() == 0, "R1 no record from reset levels", exp_q.size(), 0);

        // R2 R4 R5: single change, zero seconds
        fire(4'b1011, 1'b1);
        drain("R2 single change record");
        tick_n(3);
        fire(4'b1001, 1'b1);          // channel 1 at 3 s
        drain("R5 tick count record");
        // R3: simultaneous changes report lowest index
        fire(cur ^ 4'b1100, 1'b1);    // channel 2
        drain("R3 two bits changed");
        tick_n(1);
        fire(cur ^ 4'b1111, 1'b1);    // channel 0
        drain("R3 all bits changed");
        fire(cur ^ 4'b1000, 1'b1);    // channel 3
        drain("R3 top channel");
        // R2: held level gives nothing more
        repeat (20) @(negedge clk);
        chk(!mem_we, "R2 held level no write", mem_we, 0);

        // R6 R7: random ready stalls
        tick_n(1000);
        rdy_mode = 1;
        for (int i = 0; i < 6; i++) begin
            fire(cur ^ 4'(1 << (i % 4)), 1'b1);
            tick_n(i + 1);
            drain("R6 random ready");
        end

        // R7 R8: stalled store, three events back to back
        rdy_mode = 2;
        repeat (2) @(negedge clk);
        fire(cur ^ 4'b0001, 1'b1);
        fire(cur ^ 4'b0100, 1'b1);    // held in pending slot
        fire(cur ^ 4'b0010, 1'b0);    // both occupied: dropped
        repeat (2) @(negedge clk);
        #1;
        a0 = mem_addr;
        d0 = mem_data;
        repeat (8) @(negedge clk);
        #1;
        chk(mem_we, "R7 request held while stalled", mem_we, 1);
        chk(mem_addr == a0 && mem_data == d0, "R7 byte held while stalled",
            {mem_addr, mem_data}, {a0, d0});
        chk(int'(mem_addr) == (nrec - 2) * 4, "R6 stalled record base address",
            mem_addr, (nrec - 2) * 4);
        rdy_mode = 0;
        drain("R8 pending then drop");

        // R8: pending refilled the moment the writer frees
        rdy_mode = 1;
        for (int i = 0; i < 4; i++) begin
            fire(cur ^ 4'(1 << (3 - i)), 1'b1);
            tick_n(2);
            fire(cur ^ 4'(1 << i), 1'b1);
            drain("R8 back to back with random ready");
        end
        rdy_mode = 0;

        // R9: fill to capacity
        while (nrec < 2000) begin
            if (nrec == 1999) chk(!full, "R9 full low before last", full, 0);
            fire(cur ^ 4'(1 << (nrec % 4)), 1'b1);
            drain("R9 fill");
        end
        chk(full, "R9 full after 2000 records", full, 1);
        fire(cur ^ 4'b0001, 1'b0);
        fire(cur ^ 4'b0010, 1'b0);
        repeat (20) @(negedge clk);
        chk(!mem_we, "R9 no write once full", mem_we, 0);
        chk(full, "R9 full stays high", full, 1);
        chk(exp_q.size() == 0, "R9 scoreboard empty", exp_q.size(), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule